// File: doc/BRIEF.md
# Coprocessor Operand Transfer Controller

This block moves one 16-bit operand between memory and an attached numeric coprocessor each time the coprocessor asks for it. The coprocessor raises an asynchronous request line. The controller resynchronizes that line and then issues two bus operations in a row. The first is always a read and the second is always a write. The order of memory and I/O depends on the transfer direction. The I/O side always targets the coprocessor's data port at the fixed I/O address 0x00FA.

A separate bus sequencer carries out each requested operation and pulses a done strobe when that operation completes. It may add any number of wait states first. The controller keeps the word returned by the read in an internal register and drives it as write data in the following write. The acknowledge output is high for the whole first operation only. It drops as soon as that operation completes, which gives the coprocessor time to remove its request before the controller could accept a second transfer.

Top module: `cop_xfer_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `busReq` and `opAck` are 0.
- R2: `opReq` passes through a two-stage synchronizer. When `opReq` rises while the controller is idle, `busReq` and `opAck` first read 1 after the third rising clock edge.
- R3: When `dirToMem` = 1 (coprocessor to memory), the first operation is an I/O read: `busIsIo` = 1, `busIsWrite` = 0, and `busAddr` = 0x00FA zero-extended.
- R4: When `dirToMem` = 1, the second operation is a memory write (`busIsIo` = 0, `busIsWrite` = 1) to the operand address, with `busWrData` equal to the `busRdData` value present when the first operation's `busDone` was sampled.
- R5: When `dirToMem` = 0 (memory to coprocessor), the first operation is a memory read of the operand address: `busIsIo` = 0 and `busIsWrite` = 0.
- R6: When `dirToMem` = 0, the second operation is an I/O write to 0x00FA with `busWrData` equal to the word captured from the first read.
- R7: `opAck` is 1 for exactly the cycles of the first operation. It falls on the clock edge that samples `busDone` for that operation, and the second operation begins at that same edge.
- R8: While `busDone` is 0, a pending operation keeps `busReq`, `busIsIo`, `busIsWrite` and `busAddr` unchanged, so any number of wait states is allowed.
- R9: After the second operation completes, `busReq` is 0 for at least one cycle. If the synchronized `opReq` is still 1 at that point, a new pair starts on the following cycle. A request is never taken up while a pair is running.
- R10: Direction and operand address are captured when the pair starts. Changes to `dirToMem` or `operandAddr` during the pair do not affect it.
- R11: Pulling `rstN` low during a pair aborts the pair at once: `busReq` and `opAck` go to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opReq | input | 1 | Asynchronous operand transfer request from the coprocessor |
| dirToMem | input | 1 | 1: coprocessor to memory, 0: memory to coprocessor |
| operandAddr | input | ADDR_W (24) | Memory address of the operand |
| busDone | input | 1 | Current bus operation completes this cycle |
| busRdData | input | 16 | Read data, valid together with `busDone` |
| busReq | output | 1 | A bus operation is requested |
| busIsIo | output | 1 | 1: I/O space, 0: memory space |
| busIsWrite | output | 1 | 1: write, 0: read |
| busAddr | output | ADDR_W (24) | Operation address |
| busWrData | output | 16 | Write data; 0 when no write is pending |
| opAck | output | 1 | Acknowledge, high during the first operation |

## Verification
A wrong state register shows at the ports within one cycle. `opAck` would stay high into the write, a second pair would start with no idle cycle between them, or the read would be flagged as a write. If the direction or address register were not frozen, or were loaded at the wrong time, the error would appear on `busAddr` or `busIsIo` in the second operation. A failed data capture shows up as a wrong `busWrData` in the cycle right after the first `busDone`. Synchronizer depth faults change the number of edges before `opAck` rises, so latency is checked cycle-exactly.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
  localparam int DATA_W = 16;
  localparam logic [15:0] COP_PORT = 16'h00FA;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } xferState_e;

  typedef struct packed {
    logic latchCmd;   // freeze direction and address
    logic captureRd;  // store read word
    logic inFirst;
    logic inSecond;
  } ctrlStrobes_t;
endpackage

// File: rtl/cop_xfer_sync.sv
module cop_xfer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/cop_xfer_fsm.sv
module cop_xfer_fsm
  import cop_xfer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqSync,
  input  logic         busDone,
  output ctrlStrobes_t strobes,
  output logic         busReq,
  output logic         opAck
);
  xferState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqSync) begin
          strobes.latchCmd = 1'b1;
          nextState        = ST_FIRST;
        end
      end
      ST_FIRST: begin
        strobes.inFirst   = 1'b1;
        strobes.captureRd = busDone;
        if (busDone) nextState = ST_SECOND;
      end
      ST_SECOND: begin
        strobes.inSecond = 1'b1;
        if (busDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busReq = (state == ST_FIRST) || (state == ST_SECOND);
  assign opAck  = (state == ST_FIRST);
endmodule

// File: rtl/cop_xfer_datapath.sv
module cop_xfer_datapath
  import cop_xfer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              dirToMem,
  input  logic [ADDR_W-1:0] operandAddr,
  input  logic [DATA_W-1:0] busRdData,
  output logic              busIsIo,
  output logic              busIsWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData
);
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(COP_PORT);

  logic              dirReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= 1'b0;
      addrReg <= '0;
    end else if (strobes.latchCmd) begin
      dirReg  <= dirToMem;
      addrReg <= operandAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dataReg <= '0;
    else if (strobes.captureRd) dataReg <= busRdData;
  end

  // first op: I/O when draining the coprocessor; second op: the other space
  always_comb begin
    busIsIo    = 1'b0;
    busIsWrite = strobes.inSecond;
    if (strobes.inFirst)       busIsIo = dirReg;
    else if (strobes.inSecond) busIsIo = !dirReg;
    busAddr   = busIsIo ? PORT_ADDR : addrReg;
    busWrData = strobes.inSecond ? dataReg : '0;
  end
endmodule

// File: rtl/cop_xfer_ctrl.sv
module cop_xfer_ctrl #(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opReq,
  input  logic              dirToMem,
  input  logic [ADDR_W-1:0] operandAddr,
  input  logic              busDone,
  input  logic [15:0]       busRdData,
  output logic              busReq,
  output logic              busIsIo,
  output logic              busIsWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busWrData,
  output logic              opAck
);
  import cop_xfer_pkg::*;

  logic         reqSync;
  ctrlStrobes_t strobes;

  cop_xfer_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(opReq), .syncOut(reqSync)
  );

  cop_xfer_fsm uFsm (
    .clk(clk), .rstN(rstN), .reqSync(reqSync), .busDone(busDone),
    .strobes(strobes), .busReq(busReq), .opAck(opAck)
  );

  cop_xfer_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dirToMem(dirToMem),
    .operandAddr(operandAddr), .busRdData(busRdData),
    .busIsIo(busIsIo), .busIsWrite(busIsWrite),
    .busAddr(busAddr), .busWrData(busWrData)
  );
endmodule

// File: rtl/cop_xfer_chk.sv
module cop_xfer_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busDone,
  input logic              busReq,
  input logic              busIsIo,
  input logic              busIsWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              opAck
);
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h00FA);

  AST_ACK_MEANS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    opAck |-> busReq); // R7
  AST_ACK_FALLS_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (opAck && busDone) |=> (!opAck && busReq && busIsWrite)); // R7
  AST_PAIR_STARTS_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> opAck); // R7
  AST_FIRST_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    opAck |-> !busIsWrite); // R3
  AST_SECOND_IS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !opAck) |-> busIsWrite); // R4
  AST_IO_AT_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busIsIo) |-> (busAddr == PORT_ADDR)); // R6
  AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> (busReq && $stable(busAddr) && $stable(busIsIo)
                              && $stable(busIsWrite))); // R8
  AST_GAP_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busIsWrite && busDone) |=> !busReq); // R9
endmodule

bind cop_xfer_ctrl cop_xfer_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busDone(busDone), .busReq(busReq),
  .busIsIo(busIsIo), .busIsWrite(busIsWrite), .busAddr(busAddr), .opAck(opAck)
);

// File: tb/tb_cop_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_cop_xfer_ctrl;
  localparam int AW = 24;
  localparam logic [AW-1:0] PORT = 24'h0000FA;

  typedef struct packed {
    logic          dir;
    logic [AW-1:0] addr;
    logic [15:0]   rd;
    logic [3:0]    w1;
    logic [3:0]    w2;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 24'h001234, 16'hBEEF, 4'd0, 4'd0},
    '{1'b0, 24'hABCDE0, 16'h1357, 4'd0, 4'd0},
    '{1'b1, 24'hFFFFFE, 16'h0001, 4'd3, 4'd1},
    '{1'b0, 24'h000002, 16'hFFFF, 4'd2, 4'd4},
    '{1'b0, 24'h5A5A5A, 16'h8000, 4'd1, 4'd0}
  };

  logic clk = 0, rstN = 0, opReq = 0, dirToMem = 0, busDone = 0;
  logic [AW-1:0] operandAddr = '0;
  logic [15:0] busRdData = '0;
  logic busReq, busIsIo, busIsWrite, opAck;
  logic [AW-1:0] busAddr;
  logic [15:0] busWrData;

  int total = 0, failed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cop_xfer_ctrl dut (
    .clk(clk), .rstN(rstN), .opReq(opReq), .dirToMem(dirToMem),
    .operandAddr(operandAddr), .busDone(busDone), .busRdData(busRdData),
    .busReq(busReq), .busIsIo(busIsIo), .busIsWrite(busIsWrite),
    .busAddr(busAddr), .busWrData(busWrData), .opAck(opAck)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; opReq = 0; busDone = 0;
    @(negedge clk);
    chk(busReq == 0, "R1 busReq in reset", 32'(busReq), 0);
    chk(opAck == 0, "R1 opAck in reset", 32'(opAck), 0);
    rstN = 1;
    @(negedge clk);
    chk(busReq == 0 && opAck == 0, "R1 idle after reset", 32'({busReq, opAck}), 0);
  endtask

  // Raise request, check latency and first op fields; leaves bench at first-op negedge
  task automatic startPair(input logic dir, input logic [AW-1:0] addr);
    dirToMem = dir; operandAddr = addr; opReq = 1;
    @(negedge clk);
    chk(busReq == 0, "R2 no request after one edge", 32'(busReq), 0);
    @(negedge clk);
    chk(busReq == 0, "R2 no request after two edges", 32'(busReq), 0);
    @(negedge clk);
    chk(busReq == 1 && opAck == 1, "R2 R7 first op after third edge",
        32'({busReq, opAck}), 32'h3);
  endtask

  task automatic runPair(input vec_t v, input bit holdReq);
    logic [AW-1:0] expFirst, expSecond;
    expFirst  = v.dir ? PORT : v.addr;
    expSecond = v.dir ? v.addr : PORT;
    @(negedge clk);
    startPair(v.dir, v.addr);
    if (!holdReq) opReq = 0;
    // R10: disturb command inputs during the pair
    dirToMem = ~v.dir; operandAddr = ~v.addr;
    chk(busIsIo == v.dir && busIsWrite == 0,
        v.dir ? "R3 first op I/O read" : "R5 first op memory read",
        32'({busIsIo, busIsWrite}), 32'({v.dir, 1'b0}));
    chk(busAddr == expFirst, v.dir ? "R3 port address" : "R5 operand address",
        32'(busAddr), 32'(expFirst));
    for (int w = 0; w < int'(v.w1); w++) begin
      @(negedge clk);
      chk(busReq && opAck && busAddr == expFirst && !busIsWrite,
          "R8 first op held in wait", 32'(busAddr), 32'(expFirst));
    end
    busDone = 1; busRdData = v.rd;
    @(negedge clk);
    busDone = 0; busRdData = 16'h0;
    chk(opAck == 0 && busReq == 1, "R7 ack drops, second op starts",
        32'({busReq, opAck}), 32'h2);
    chk(busIsWrite == 1 && busIsIo == !v.dir,
        v.dir ? "R4 second op memory write" : "R6 second op I/O write",
        32'({busIsIo, busIsWrite}), 32'({!v.dir, 1'b1}));
    chk(busAddr == expSecond, "R10 second op address from latched command",
        32'(busAddr), 32'(expSecond));
    chk(busWrData == v.rd, v.dir ? "R4 write data" : "R6 write data",
        32'(busWrData), 32'(v.rd));
    for (int w = 0; w < int'(v.w2); w++) begin
      @(negedge clk);
      chk(busReq && busIsWrite && busAddr == expSecond && busWrData == v.rd,
          "R8 second op held in wait", 32'(busWrData), 32'(v.rd));
    end
    busDone = 1;
    @(negedge clk);
    busDone = 0;
    chk(busReq == 0 && opAck == 0, "R9 idle gap after pair", 32'({busReq, opAck}), 0);
    @(negedge clk);
    if (holdReq)
      chk(busReq == 1 && opAck == 1, "R9 held request starts new pair",
          32'({busReq, opAck}), 32'h3);
    else
      chk(busReq == 0, "R9 dropped request starts nothing", 32'(busReq), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    doReset();
    foreach (VECS[i]) runPair(VECS[i], 1'b0);

    // R9: request held through the pair
    runPair(VECS[1], 1'b1);
    doReset();

    // R11: reset in the middle of the first op
    @(negedge clk);
    startPair(1'b1, 24'h000100);
    #1 rstN = 0;
    #1 chk(busReq == 0 && opAck == 0, "R11 abort clears request and ack",
           32'({busReq, opAck}), 0);
    opReq = 0;
    @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    chk(busReq == 0 && opAck == 0, "R11 stays idle after abort",
        32'({busReq, opAck}), 0);

    // pair works again after abort
    runPair(VECS[0], 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule